// File: doc/BRIEF.md
# Access-Typed APB Register Bank

This block is an APB slave with a 16-bit address and 32-bit data. It holds ten word-aligned registers, and each register is built from fields. Each field has its own access type. The access type decides what a bus write does to the field, what a bus read does to it, and whether the field may be read at all. A status byte from the hardware side appears in a read-only field. A byte of hardware event bits can set a write-one-to-clear field. Every stored field value is visible on a flat output bus, and two pulse fields drive a one-cycle strobe output.

A small phase tracker follows the APB handshake through three states: IDLE, SETUP and ACCESS. The transitions are:
- IDLE goes to SETUP when PSEL rises without PENABLE.
- SETUP goes to ACCESS when PENABLE joins PSEL.
- SETUP returns to IDLE if PSEL drops.
- ACCESS stays in ACCESS while PSEL and PENABLE both stay high.
- ACCESS goes to SETUP on a new PSEL without PENABLE.
- ACCESS goes to IDLE otherwise.

A transfer takes effect only on the SETUP-to-ACCESS edge. Every register effect therefore happens exactly once per transfer.

Top module: `regbank_top`

## Requirements
- R1: PREADY is always 1. A transfer takes effect only in the first cycle with PSEL=1 and PENABLE=1 that follows a setup cycle. If PENABLE is held high longer, no second effect happens.
- R2: Registers 0 to 6 sit at consecutive word offsets 0x00 to 0x18. Register 7 is pinned at 0x40, and registers 8 and 9 follow at 0x44 and 0x48.
- R3: Offset 0x00 holds a read/write byte at [7:0] and a read-only copy of hw_status at [23:16]. All unassigned bits of every register read as 0. reg_view[32*k+31:32*k] shows register k, with pulse, reserved and read-only-from-bus bits laid out as they are stored.
- R4: Offset 0x04 holds four bytes, from [7:0] upward:
  - a clear-on-read byte (reset 0xA5), which ignores writes;
  - a set-on-read byte (reset 0x3C), which ignores writes;
  - a byte that takes writes as-is and clears on read (reset 0);
  - a byte that takes writes as-is and sets on read (reset 0).
  A read returns the value held before its side effect.
- R5: Offset 0x08 holds, from bit 0 upward:
  - [7:0], cleared by any write (reset 0x5A);
  - [15:8], set by any write (reset 0);
  - [19:16], set by a write and cleared by a read (reset 0);
  - [23:20], cleared by a write and set by a read (reset 0xF).
- R6: Offset 0x0C holds three bytes that act only on the bits written as 1:
  - [7:0] clears them (reset 0);
  - [15:8] sets them;
  - [23:16] toggles them.
  A 1 on hw_set sets the matching bit of [7:0], and it wins over a bus clear in the same cycle.
- R7: Offset 0x10 acts only on the bits written as 0:
  - [7:0] clears them (reset 0xFF);
  - [15:8] sets them (reset 0);
  - [23:16] toggles them (reset 0).
- R8: Offset 0x14 combines a masked write with a read side effect:
  - [7:0] sets on 1 and clears on read (reset 0);
  - [15:8] clears on 1 and sets on read (reset 0xFF);
  - [23:16] sets on 0 and clears on read (reset 0);
  - [31:24] clears on 0 and sets on read (reset 0xFF).
- R9: Offset 0x18 is write-only:
  - [7:0] takes the written value;
  - [15:8] clears on write (reset 0xFF);
  - [23:16] sets on write (reset 0).
  A read of it gives PSLVERR=1 and PRDATA=0, and leaves the contents unchanged.
- R10: Offset 0x40 [15:0] and offset 0x44 [15:0] each accept only the first write after reset. Later writes are ignored. A read of 0x44 gives PSLVERR=1 and PRDATA=0. A reset re-arms both.
- R11: A write to 0x48 raises pulse_out[7:0] for one cycle on each data bit [7:0] written as 1. It raises pulse_out[15:8] for one cycle on each data bit [15:8] written as 0. Reading 0x48 returns 0 without error.
- R12: An access to any other address, including a non-word-aligned one, gives PSLVERR=1 and PRDATA=0, and changes no register.
- R13: After reset, every field holds the reset value given above (0x11 for the read/write byte at 0x00, 0 where none is given). PRDATA reads 0 outside a read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 16 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error response |
| hw_status | input | 8 | Hardware value shown in the read-only field |
| hw_set | input | 8 | Hardware set events for the write-one-to-clear byte |
| reg_view | output | 320 | Stored contents of all ten registers |
| pulse_out | output | 16 | One-cycle strobes from the pulse fields |

## Verification
The hardest case to reach is a hardware set event that lands on a write-one-to-clear bit in the exact cycle when the bus clears that same bit. The bench reaches it by raising hw_set inside the APB access cycle of a write to 0x0C. A second awkward case is the master holding PENABLE high for an extra cycle, where a read side effect or a toggle must not repeat. The bench stretches the access phase to reach it. A behavioural model of every field is compared against reg_view and pulse_out on every clock.

// File: rtl/regbank_pkg.sv
`timescale 1ns/1ps
package regbank_pkg;

    typedef enum logic [4:0] {
        ACC_RO, ACC_RW, ACC_RC, ACC_RS, ACC_WRC, ACC_WRS,
        ACC_WC, ACC_WS, ACC_WSRC, ACC_WCRS,
        ACC_W1C, ACC_W1S, ACC_W1T, ACC_W0C, ACC_W0S, ACC_W0T,
        ACC_W1SRC, ACC_W1CRS, ACC_W0SRC, ACC_W0CRS,
        ACC_WO, ACC_WOC, ACC_WOS, ACC_W1, ACC_WO1, ACC_W1P, ACC_W0P
    } acc_e;

    typedef struct packed {
        logic [7:0]  reg_idx;
        logic [7:0]  lsb;
        logic [7:0]  width;
        acc_e        acc;
        logic [31:0] rst;
    } field_t;

    localparam int NUM_REGS   = 10;
    localparam int NUM_FIELDS = 27;
    localparam int PIN_REG    = 7;
    localparam logic [15:0] PIN_OFFSET = 16'h0040;

    function automatic field_t mk(input int r, input int l, input int w,
                                  input acc_e a, input logic [31:0] v);
        field_t f;
        f.reg_idx = 8'(r);
        f.lsb     = 8'(l);
        f.width   = 8'(w);
        f.acc     = a;
        f.rst     = v;
        return f;
    endfunction

    function automatic field_t field_at(input int i);
        case (i)
            0:  return mk(0, 0,  8, ACC_RW,    32'h11);
            1:  return mk(0, 16, 8, ACC_RO,    32'h00);
            2:  return mk(1, 0,  8, ACC_RC,    32'hA5);
            3:  return mk(1, 8,  8, ACC_RS,    32'h3C);
            4:  return mk(1, 16, 8, ACC_WRC,   32'h00);
            5:  return mk(1, 24, 8, ACC_WRS,   32'h00);
            6:  return mk(2, 0,  8, ACC_WC,    32'h5A);
            7:  return mk(2, 8,  8, ACC_WS,    32'h00);
            8:  return mk(2, 16, 4, ACC_WSRC,  32'h0);
            9:  return mk(2, 20, 4, ACC_WCRS,  32'hF);
            10: return mk(3, 0,  8, ACC_W1C,   32'h00);
            11: return mk(3, 8,  8, ACC_W1S,   32'h00);
            12: return mk(3, 16, 8, ACC_W1T,   32'h00);
            13: return mk(4, 0,  8, ACC_W0C,   32'hFF);
            14: return mk(4, 8,  8, ACC_W0S,   32'h00);
            15: return mk(4, 16, 8, ACC_W0T,   32'h00);
            16: return mk(5, 0,  8, ACC_W1SRC, 32'h00);
            17: return mk(5, 8,  8, ACC_W1CRS, 32'hFF);
            18: return mk(5, 16, 8, ACC_W0SRC, 32'h00);
            19: return mk(5, 24, 8, ACC_W0CRS, 32'hFF);
            20: return mk(6, 0,  8, ACC_WO,    32'h00);
            21: return mk(6, 8,  8, ACC_WOC,   32'hFF);
            22: return mk(6, 16, 8, ACC_WOS,   32'h00);
            23: return mk(7, 0, 16, ACC_W1,    32'h0000);
            24: return mk(8, 0, 16, ACC_WO1,   32'h0000);
            25: return mk(9, 0,  8, ACC_W1P,   32'h00);
            default: return mk(9, 8, 8, ACC_W0P, 32'h00);
        endcase
    endfunction

    function automatic logic [15:0] reg_offset(input int r);
        if (r < PIN_REG) return 16'(r * 4);
        return PIN_OFFSET + 16'((r - PIN_REG) * 4);
    endfunction

    function automatic bit acc_rd_clear(input acc_e a);
        return a inside {ACC_RC, ACC_WRC, ACC_WSRC, ACC_W1SRC, ACC_W0SRC};
    endfunction

    function automatic bit acc_rd_set(input acc_e a);
        return a inside {ACC_RS, ACC_WRS, ACC_WCRS, ACC_W1CRS, ACC_W0CRS};
    endfunction

    function automatic bit acc_wonly(input acc_e a);
        return a inside {ACC_WO, ACC_WOC, ACC_WOS, ACC_WO1};
    endfunction

    function automatic bit acc_once(input acc_e a);
        return a inside {ACC_W1, ACC_WO1};
    endfunction

    function automatic bit acc_pulse(input acc_e a);
        return a inside {ACC_W1P, ACC_W0P};
    endfunction

endpackage

// File: rtl/regbank_apb_fsm.sv
`timescale 1ns/1ps
module regbank_apb_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic rd_stb,
    output logic wr_stb
);
    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACCESS} phase_e;

    phase_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:   if (psel && !penable) state_d = PH_SETUP;
            PH_SETUP:  if (!psel) state_d = PH_IDLE;
                       else if (penable) state_d = PH_ACCESS;
            PH_ACCESS: if (!psel) state_d = PH_IDLE;
                       else if (!penable) state_d = PH_SETUP;
            default:   state_d = PH_IDLE;
        endcase
    end

    // The first access cycle after setup is the only one that acts.
    always_comb begin
        rd_stb = (state_q == PH_SETUP) && psel && penable && !pwrite;
        wr_stb = (state_q == PH_SETUP) && psel && penable && pwrite;
    end

    // R1: strobes can never fall on two consecutive cycles
    p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || wr_stb) |=> !(rd_stb || wr_stb));

endmodule

// File: rtl/regbank_field.sv
`timescale 1ns/1ps
module regbank_field
    import regbank_pkg::*;
#(
    parameter int           W   = 8,
    parameter acc_e         ACC = ACC_RW,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_val,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q,
    output logic [W-1:0] rdata,
    output logic [W-1:0] pulse
);
    localparam bit CLR_RD = acc_rd_clear(ACC);
    localparam bit SET_RD = acc_rd_set(ACC);
    localparam bit WONLY  = acc_wonly(ACC);
    localparam bit ONCE   = acc_once(ACC);
    localparam bit PULSED = acc_pulse(ACC);

    logic [W-1:0] val_q, val_d, pulse_q, pulse_d;
    logic         once_q, once_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q   <= RST;
            pulse_q <= '0;
            once_q  <= 1'b0;
        end else begin
            val_q   <= val_d;
            pulse_q <= pulse_d;
            once_q  <= once_d;
        end
    end

    always_comb begin
        val_d   = val_q;
        once_d  = once_q;
        pulse_d = '0;
        if (wr_en) begin
            case (ACC)
                ACC_RW, ACC_WRC, ACC_WRS, ACC_WO: val_d = wdata;
                ACC_WC, ACC_WOC, ACC_WCRS:        val_d = '0;
                ACC_WS, ACC_WOS, ACC_WSRC:        val_d = '1;
                ACC_W1C, ACC_W1CRS:               val_d = val_q & ~wdata;
                ACC_W1S, ACC_W1SRC:               val_d = val_q | wdata;
                ACC_W1T:                          val_d = val_q ^ wdata;
                ACC_W0C, ACC_W0CRS:               val_d = val_q & wdata;
                ACC_W0S, ACC_W0SRC:               val_d = val_q | ~wdata;
                ACC_W0T:                          val_d = val_q ^ ~wdata;
                ACC_W1, ACC_WO1: begin
                    if (!once_q) begin
                        val_d  = wdata;
                        once_d = 1'b1;
                    end
                end
                ACC_W1P:                          pulse_d = wdata;
                ACC_W0P:                          pulse_d = ~wdata;
                default: ;
            endcase
        end else if (rd_en) begin
            if (CLR_RD)      val_d = '0;
            else if (SET_RD) val_d = '1;
        end
        // hardware set is applied last so it overrides a bus clear
        val_d = val_d | hw_set;
    end

    assign q     = (ACC == ACC_RO) ? hw_val : (PULSED ? '0 : val_q);
    assign rdata = WONLY ? '0 : q;
    assign pulse = pulse_q;

    generate
        if (CLR_RD) begin : g_chk_clr
            // R4 / R8: read leaves the field all zero
            p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
                rd_en |=> val_q == '0);
        end
        if (SET_RD) begin : g_chk_set
            // R4 / R8: read leaves the field all ones
            p_read_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
                rd_en |=> val_q == '1);
        end
        if (ONCE) begin : g_chk_once
            p_once_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (once_q && wr_en) |=> $stable(val_q));
        end
        if (PULSED) begin : g_chk_pulse
            p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
                (|pulse_q) |=> (pulse_q == '0));
        end
        if (ACC == ACC_W1C) begin : g_chk_w1c
            p_hw_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (|hw_set) |=> ((val_q & $past(hw_set)) == $past(hw_set)));
        end
    endgenerate

endmodule

// File: rtl/regbank_top.sv
`timescale 1ns/1ps
module regbank_top
    import regbank_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int STAT_W  = 8,
    parameter int SET_W   = 8,
    parameter int PULSE_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         psel,
    input  logic                         penable,
    input  logic                         pwrite,
    input  logic [ADDR_W-1:0]            paddr,
    input  logic [DATA_W-1:0]            pwdata,
    output logic [DATA_W-1:0]            prdata,
    output logic                         pready,
    output logic                         pslverr,
    input  logic [STAT_W-1:0]            hw_status,
    input  logic [SET_W-1:0]             hw_set,
    output logic [NUM_REGS*DATA_W-1:0]   reg_view,
    output logic [PULSE_W-1:0]           pulse_out
);
    localparam int IDX_W  = $clog2(NUM_REGS);
    localparam int VIEW_W = NUM_REGS * DATA_W;

    logic             rd_stb, wr_stb;
    logic             hit;
    logic [IDX_W-1:0] sel;
    logic [NUM_REGS-1:0] reg_wonly;
    logic [DATA_W-1:0] rd_word, pulse_vec;
    logic [DATA_W-1:0] stat_ext, set_ext;
    logic [DATA_W-1:0] fld_q     [NUM_FIELDS];
    logic [DATA_W-1:0] fld_rd    [NUM_FIELDS];
    logic [DATA_W-1:0] fld_pulse [NUM_FIELDS];

    regbank_apb_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .rd_stb  (rd_stb),
        .wr_stb  (wr_stb)
    );

    assign stat_ext = DATA_W'(hw_status);
    assign set_ext  = DATA_W'(hw_set);

    // address decode against the allocated offsets
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (paddr == ADDR_W'(reg_offset(r))) begin
                hit = 1'b1;
                sel = IDX_W'(r);
            end
        end
    end

    always_comb begin
        field_t fd;
        reg_wonly = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            fd = field_at(i);
            if (acc_wonly(fd.acc)) reg_wonly[fd.reg_idx] = 1'b1;
        end
    end

    generate
        for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
            localparam field_t D  = field_at(i);
            localparam int     FW = int'(D.width);
            localparam int     FL = int'(D.lsb);
            localparam int     FR = int'(D.reg_idx);
            localparam logic [FW-1:0] FRST = FW'(D.rst);

            logic          mine;
            logic [FW-1:0] hv, hs, q, rd, pl;

            assign mine = hit && (sel == IDX_W'(FR));
            assign hv   = (D.acc == ACC_RO)  ? stat_ext[FW-1:0] : '0;
            assign hs   = (D.acc == ACC_W1C) ? set_ext[FW-1:0]  : '0;

            regbank_field #(.W(FW), .ACC(D.acc), .RST(FRST)) u_field (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (wr_stb && mine),
                .rd_en  (rd_stb && mine),
                .wdata  (pwdata[FL +: FW]),
                .hw_val (hv),
                .hw_set (hs),
                .q      (q),
                .rdata  (rd),
                .pulse  (pl)
            );

            assign fld_q[i]     = DATA_W'(q)  << FL;
            assign fld_rd[i]    = DATA_W'(rd) << FL;
            assign fld_pulse[i] = DATA_W'(pl) << FL;
        end
    endgenerate

    always_comb begin
        field_t fd;
        rd_word   = '0;
        pulse_vec = '0;
        reg_view  = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            fd = field_at(i);
            if (IDX_W'(fd.reg_idx) == sel) rd_word = rd_word | fld_rd[i];
            pulse_vec = pulse_vec | fld_pulse[i];
            reg_view[int'(fd.reg_idx)*DATA_W +: DATA_W] =
                reg_view[int'(fd.reg_idx)*DATA_W +: DATA_W] | fld_q[i];
        end
    end

    logic rd_err;
    assign rd_err    = !hit || reg_wonly[sel];
    assign pready    = 1'b1;
    assign pslverr   = (rd_stb && rd_err) || (wr_stb && !hit);
    assign prdata    = (rd_stb && !rd_err) ? rd_word : '0;
    assign pulse_out = pulse_vec[PULSE_W-1:0];

    logic unused_bits;
    assign unused_bits = ^{pulse_vec[DATA_W-1:PULSE_W], VIEW_W'(0)};

    // R12: unmapped reads return zero with an error
    p_unmapped_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !hit) |-> (prdata == '0 && pslverr));

    // R1: an error response only appears in an access phase
    p_err_in_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> (psel && penable));

endmodule

// File: tb/regbank_top_tb.sv
`timescale 1ns/1ps
module regbank_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NF = 27;
    localparam int NR = 10;

    localparam int K_RO=0, K_RW=1, K_RC=2, K_RS=3, K_WRC=4, K_WRS=5, K_WC=6, K_WS=7,
                   K_WSRC=8, K_WCRS=9, K_W1C=10, K_W1S=11, K_W1T=12, K_W0C=13,
                   K_W0S=14, K_W0T=15, K_W1SRC=16, K_W1CRS=17, K_W0SRC=18,
                   K_W0CRS=19, K_WO=20, K_WOC=21, K_WOS=22, K_W1=23, K_WO1=24,
                   K_W1P=25, K_W0P=26;

    int f_reg [NF] = '{0,0,1,1,1,1,2,2,2,2,3,3,3,4,4,4,5,5,5,5,6,6,6,7,8,9,9};
    int f_lsb [NF] = '{0,16,0,8,16,24,0,8,16,20,0,8,16,0,8,16,0,8,16,24,0,8,16,0,0,0,8};
    int f_w   [NF] = '{8,8,8,8,8,8,8,8,4,4,8,8,8,8,8,8,8,8,8,8,8,8,8,16,16,8,8};
    int f_acc [NF] = '{K_RW,K_RO,K_RC,K_RS,K_WRC,K_WRS,K_WC,K_WS,K_WSRC,K_WCRS,
                       K_W1C,K_W1S,K_W1T,K_W0C,K_W0S,K_W0T,K_W1SRC,K_W1CRS,K_W0SRC,
                       K_W0CRS,K_WO,K_WOC,K_WOS,K_W1,K_WO1,K_W1P,K_W0P};
    logic [31:0] f_rst [NF] = '{32'h11,0,32'hA5,32'h3C,0,0,32'h5A,0,0,32'hF,0,0,0,
                                32'hFF,0,0,0,32'hFF,0,32'hFF,0,32'hFF,0,0,0,0,0};

    logic clk = 1'b0, rst_n = 1'b0;
    logic psel = 0, penable = 0, pwrite = 0;
    logic [15:0] paddr = '0;
    logic [31:0] pwdata = '0, prdata;
    logic pready, pslverr;
    logic [7:0] hw_status = 8'h5C, hw_set = '0;
    logic [NR*32-1:0] reg_view;
    logic [15:0] pulse_out;

    logic [31:0] m_val [NF];
    bit          m_once [NF];
    logic [15:0] m_pulse = '0;
    int  n_chk = 0, n_fail = 0;
    bit  mon_on = 0, done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regbank_top u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .hw_status(hw_status), .hw_set(hw_set),
        .reg_view(reg_view), .pulse_out(pulse_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] fmask(input int w);
        return (32'd1 << w) - 32'd1;
    endfunction

    function automatic int addr2reg(input logic [15:0] a);
        for (int r = 0; r < NR; r++) begin
            if (a == ((r < 7) ? 16'(r*4) : 16'(16'h40 + (r-7)*4))) return r;
        end
        return -1;
    endfunction

    function automatic bit reg_wonly(input int r);
        for (int i = 0; i < NF; i++)
            if (f_reg[i] == r && f_acc[i] inside {K_WO, K_WOC, K_WOS, K_WO1}) return 1;
        return 0;
    endfunction

    function automatic logic [31:0] view_word(input int r);
        logic [31:0] v = '0;
        for (int i = 0; i < NF; i++) begin
            if (f_reg[i] != r) continue;
            if (f_acc[i] == K_RO) v |= (32'(hw_status) & fmask(f_w[i])) << f_lsb[i];
            else if (!(f_acc[i] inside {K_W1P, K_W0P})) v |= m_val[i] << f_lsb[i];
        end
        return v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NF; i++) begin
            m_val[i]  = f_rst[i];
            m_once[i] = 0;
        end
        m_pulse = '0;
    endtask

    task automatic model_write(input int r, input logic [31:0] d);
        for (int i = 0; i < NF; i++) begin
            logic [31:0] mk, wf, v;
            if (f_reg[i] != r) continue;
            mk = fmask(f_w[i]);
            wf = (d >> f_lsb[i]) & mk;
            v  = m_val[i];
            case (f_acc[i])
                K_RW, K_WRC, K_WRS, K_WO: v = wf;
                K_WC, K_WOC, K_WCRS:      v = 0;
                K_WS, K_WOS, K_WSRC:      v = mk;
                K_W1C, K_W1CRS:           v = v & ~wf;
                K_W1S, K_W1SRC:           v = v | wf;
                K_W1T:                    v = v ^ wf;
                K_W0C, K_W0CRS:           v = v & wf;
                K_W0S, K_W0SRC:           v = v | ~wf;
                K_W0T:                    v = v ^ ~wf;
                K_W1, K_WO1: if (!m_once[i]) begin v = wf; m_once[i] = 1; end
                K_W1P: m_pulse |= 16'(wf << f_lsb[i]);
                K_W0P: m_pulse |= 16'((~wf & mk) << f_lsb[i]);
                default: ;
            endcase
            m_val[i] = v & mk;
        end
    endtask

    task automatic model_read(input int r);
        for (int i = 0; i < NF; i++) begin
            if (f_reg[i] != r) continue;
            if (f_acc[i] inside {K_RC, K_WRC, K_WSRC, K_W1SRC, K_W0SRC}) m_val[i] = 0;
            if (f_acc[i] inside {K_RS, K_WRS, K_WCRS, K_W1CRS, K_W0CRS}) m_val[i] = fmask(f_w[i]);
        end
    endtask

    // one APB transfer; hold stretches the access phase by one cycle
    task automatic xfer(input bit wr, input logic [15:0] a, input logic [31:0] d,
                        input logic [7:0] setv, input bit hold, input string req);
        int r;
        bit e_err;
        logic [31:0] e_rd;
        r     = addr2reg(a);
        e_err = (r < 0) || (!wr && reg_wonly(r));
        @(negedge clk);
        psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1; hw_set = setv;
        e_rd = (!wr && !e_err) ? view_word(r) : 32'h0;
        #1;
        chk(req, prdata, e_rd);
        chk(req, 32'(pslverr), 32'(e_err));
        chk("R1 pready", 32'(pready), 32'd1);
        @(posedge clk); #1;
        if (r >= 0 && !(wr == 0 && e_err)) begin
            if (wr) model_write(r, d);
            else    model_read(r);
        end
        m_val[10] |= 32'(setv);
        if (hold) begin
            @(negedge clk);
            hw_set = 0;
            #1 chk("R1 hold", 32'(pslverr), 32'd0);
            @(posedge clk); #1;
        end
        @(negedge clk);
        psel = 0; penable = 0; hw_set = 0;
        @(posedge clk); #1;
        m_pulse = '0;
    endtask

    task automatic wr32(input logic [15:0] a, input logic [31:0] d, input string req);
        xfer(1, a, d, 8'h0, 0, req);
    endtask

    task automatic rd32(input logic [15:0] a, input string req);
        xfer(0, a, 32'h0, 8'h0, 0, req);
    endtask

    task automatic do_reset();
        mon_on = 0;
        @(negedge clk);
        rst_n = 0;
        #1;
        chk("R13 prdata", prdata, 32'h0);
        chk("R13 pslverr", 32'(pslverr), 32'h0);
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1;
        mon_on = 1;
    endtask

    // per-cycle comparison of all outputs against the model
    always @(posedge clk) begin
        #3;
        if (mon_on && rst_n && !done) begin
            for (int r = 0; r < NR; r++)
                chk($sformatf("R3 view reg%0d", r), reg_view[r*32 +: 32], view_word(r));
            chk("R11 pulse", 32'(pulse_out), 32'(m_pulse));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        rd32(16'h0000, "R13 reset read");
        // R3 field placement and reserved bits
        wr32(16'h0000, 32'hFFFF_FFFF, "R3 write");
        rd32(16'h0000, "R3 readback");
        hw_status = 8'hA3;
        rd32(16'h0000, "R3 ro tracks");
        // R2 and R12 address allocation
        rd32(16'h0040, "R2 pinned");
        rd32(16'h0048, "R2 after pin");
        rd32(16'h001C, "R12 gap");
        rd32(16'h003C, "R12 below pin");
        rd32(16'h004C, "R12 past end");
        rd32(16'h0002, "R12 unaligned");
        wr32(16'h0020, 32'hFFFF_FFFF, "R12 write");
        // R4 read side effects
        rd32(16'h0004, "R4 first");
        rd32(16'h0004, "R4 second");
        wr32(16'h0004, 32'h1234_5678, "R4 write");
        rd32(16'h0004, "R4 after write");
        rd32(16'h0004, "R4 settled");
        // R5 whole-field write effects
        rd32(16'h0008, "R5 initial");
        wr32(16'h0008, 32'h0000_0000, "R5 write");
        rd32(16'h0008, "R5 after write");
        rd32(16'h0008, "R5 after read");
        // R6 write-one masks and hardware set
        @(negedge clk); hw_set = 8'hF0;
        @(posedge clk); #1 m_val[10] |= 32'hF0;
        @(negedge clk); hw_set = 8'h00;
        wr32(16'h000C, 32'h000F_3330, "R6 masked");
        rd32(16'h000C, "R6 readback");
        xfer(1, 16'h000C, 32'h0000_00C0, 8'h80, 0, "R6 collision");
        rd32(16'h000C, "R6 set wins");
        // R7 write-zero masks
        wr32(16'h0010, 32'h00F0_F00F, "R7 masked");
        rd32(16'h0010, "R7 readback");
        // R8 combined
        rd32(16'h0014, "R8 first");
        wr32(16'h0014, 32'h0F0F_F00F, "R8 write");
        rd32(16'h0014, "R8 read");
        rd32(16'h0014, "R8 after read");
        // R9 write-only
        wr32(16'h0018, 32'h00AB_55CD, "R9 write");
        rd32(16'h0018, "R9 read error");
        // R10 write once
        wr32(16'h0040, 32'h0000_1234, "R10 first");
        wr32(16'h0040, 32'h0000_FFFF, "R10 second");
        rd32(16'h0040, "R10 readback");
        wr32(16'h0044, 32'h0000_BEEF, "R10 wo1 first");
        wr32(16'h0044, 32'h0000_0001, "R10 wo1 second");
        rd32(16'h0044, "R10 wo1 read");
        // R11 pulses
        wr32(16'h0048, 32'h0000_F00F, "R11 pulse write");
        wr32(16'h0048, 32'h0000_FF00, "R11 quiet write");
        rd32(16'h0048, "R11 read");
        // R1 stretched access phase: one toggle, one clear only
        xfer(1, 16'h000C, 32'h00FF_0000, 8'h0, 1, "R1 held write");
        xfer(0, 16'h0014, 32'h0, 8'h0, 1, "R1 held read");
        rd32(16'h000C, "R1 toggle once");
        // R13 second reset re-arms write-once
        do_reset();
        rd32(16'h0004, "R13 after reset");
        wr32(16'h0040, 32'h0000_00AA, "R10 rearmed");
        rd32(16'h0040, "R10 rearmed read");
        repeat (2) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule